// File: doc/BRIEF.md
# Cyclic-Sense Sleep Mode Controller

This block is the mode-control state machine of a power-management companion chip. A host selects one of three operating modes through a simple command strobe: active, standby or a low-power sleep. The same strobe carries a sense-period code and an on-time code. In active mode the main regulator and both bus transceivers are enabled. In standby only the regulator runs. In sleep the regulator and both transceivers are off, and a high-side switch that powers external wake circuitry is pulsed periodically.

While asleep the block watches four monitor inputs and two wake detectors, one from the CAN transceiver and one from the LIN transceiver. A change on one of the first three monitors counts only while the sense switch is on. The fourth monitor and both transceiver wakes count at any time. Any accepted wake returns the block to standby, not to active. The wake source is kept in a status field that clears when read. A transceiver that caused the wake has its receive-line pull-low flag raised, and the flag stays up until the host commands active mode.

Top module: `sense_sleep_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the block is in standby (`mode_o`=0): `reg_en`=1, `can_en`=`lin_en`=0, `hs_en`=0, `wake_src`=0 and both pull-low flags are 0.
- R2: A command with mode field 3'b100 issued outside sleep, with `mon_init_ok`=1, enters sleep (`mode_o`=2) on the next cycle. In sleep `reg_en`, `can_en` and `lin_en` are all 0. A sleep command issued while already asleep changes nothing.
- R3: A sleep command issued while `mon_init_ok`=0 puts the block in standby instead of sleep.
- R4: Mode encoding on `mode_o` is 0 standby, 1 active, 2 sleep. A command with mode field 3'b0xx selects active, where all three enables are 1. A command with 3'b101, 3'b110 or 3'b111 selects standby, where `reg_en`=1 and `can_en`=`lin_en`=0.
- R5: In sleep, `hs_en` starts low and stays low for the sense period, then goes high for the on-time, and this repeats. Period code 0 to 3 gives 160, 320, 640 or 1280 ticks. On-time bit 0 gives 1 tick and bit 1 gives 10 ticks. Outside sleep, `hs_en` is 0.
- R6: A level on `mon_in[0..2]` that differs from the level sampled when sleep was commanded wakes the block only in a cycle where `hs_en`=1. Such a difference during the off phase is ignored.
- R7: A difference on `mon_in[3]`, a `can_wake` pulse or a `lin_wake` pulse wakes the block in either phase of sleep.
- R8: An accepted wake moves the block to standby on the next cycle, with `reg_en`=1. A wake takes priority over a command in the same cycle. Wake inputs have no effect outside sleep.
- R9: `wake_src` bit positions are: [0..2] monitors 1..3, [3] monitor 4, [4] CAN, [5] LIN. Every source accepted in a wake cycle sets its bit. A `stat_rd` strobe clears the field on the next cycle, but a bit being set in that same cycle still wins.
- R10: `can_rxd_low` or `lin_rxd_low` goes to 1 when that transceiver wakes the block. It clears only when an active-mode command is accepted.
- R11: The period and on-time codes are latched from any command accepted outside sleep. Sleep timing advances only in cycles where `tick`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | 10 kHz timebase enable, one cycle wide |
| cmd_valid | input | 1 | Command strobe |
| cmd_mode | input | 3 | Requested mode field |
| cmd_period | input | 2 | Sense-period code |
| cmd_ontime | input | 1 | On-time select |
| mon_init_ok | input | 1 | Monitor initialisation result for a sleep command |
| stat_rd | input | 1 | Status read strobe (clears `wake_src`) |
| mon_in | input | NMON | Monitor input levels |
| can_wake | input | 1 | CAN transceiver wake detection |
| lin_wake | input | 1 | LIN transceiver wake detection |
| reg_en | output | 1 | Main regulator enable |
| can_en | output | 1 | CAN transceiver and termination enable |
| lin_en | output | 1 | LIN transceiver and termination enable |
| hs_en | output | 1 | High-side sense switch enable |
| can_rxd_low | output | 1 | CAN receive-line pull-low flag |
| lin_rxd_low | output | 1 | LIN receive-line pull-low flag |
| wake_src | output | NMON+2 | Latched wake-source status |
| mode_o | output | 2 | Current mode |

## Verification
Several properties are checked on every cycle. Sleep is reached only through a sleep command with a good initialisation. A failed initialisation lands in standby. Any wake leaves sleep for standby. A gated-monitor status bit can rise only after a cycle with the switch on. A pull-low flag can rise only after its transceiver's wake. The phase counter stays within its limit. The exact lengths of the off and on phases for each code, the effect of a slow tick, accumulation and read-clear of the status field, and flag clearing by an active command are shown only by the bench. It compares a cycle model against the ports over directed and random sequences.

// File: rtl/ss_pkg.sv
// Shared types for the cyclic-sense sleep controller.
// Assumes: mode encoding below is visible on the top-level mode output.
package ss_pkg;
    typedef enum logic [1:0] {
        MD_STANDBY = 2'd0,
        MD_ACTIVE  = 2'd1,
        MD_SLEEP   = 2'd2
    } md_e;

    localparam logic [2:0] CMD_SLEEP = 3'b100;
endpackage

// File: rtl/ss_sense_timer.sv
// Phase timer for the sense switch: off for the period, on for the on-time.
// Assumes: run is high only in sleep; the counter restarts when run drops;
// limits fit in CNT_W bits.
module ss_sense_timer #(
    parameter int unsigned CNT_W    = 12,
    parameter int unsigned PER_BASE = 160,
    parameter int unsigned ON_SHORT = 1,
    parameter int unsigned ON_LONG  = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       tick,
    input  logic [1:0] per_code,
    input  logic       on_code,
    output logic       hs_on
);
    logic [CNT_W-1:0] cnt;
    logic             on_ph;
    logic [CNT_W-1:0] per_lim;
    logic [CNT_W-1:0] on_lim;
    logic [CNT_W-1:0] lim;

    // Phase lengths derived from the latched codes.
    always_comb begin
        per_lim = CNT_W'(PER_BASE) << per_code;
        on_lim  = on_code ? CNT_W'(ON_LONG) : CNT_W'(ON_SHORT);
        lim     = on_ph ? on_lim : per_lim;
    end

    // Count ticks within a phase and flip the phase at its limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt   <= '0;
            on_ph <= 1'b0;
        end else if (tick) begin
            if (cnt == lim - CNT_W'(1)) begin
                cnt   <= '0;
                on_ph <= ~on_ph;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    assign hs_on = run && on_ph;

    AST_CNT_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < lim)); // R5
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> (!run || $stable(cnt))); // R11
endmodule

// File: rtl/ss_wake_detect.sv
// Wake qualifier: compares monitors against levels captured at sleep entry,
// gates the first NGATED monitors with the switch-on phase, and adds the
// two transceiver wakes.
// Assumes: capture pulses in the cycle a sleep command is accepted.
module ss_wake_detect #(
    parameter int unsigned NMON   = 4,
    parameter int unsigned NGATED = 3,
    localparam int unsigned WV    = NMON + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic            in_sleep,
    input  logic            hs_on,
    input  logic [NMON-1:0] mon_in,
    input  logic            can_wake,
    input  logic            lin_wake,
    output logic [WV-1:0]   wake_vec,
    output logic            wake_any
);
    logic [NMON-1:0] mon_ref;
    logic [NMON-1:0] hit;

    // Capture monitor reference levels when sleep is entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mon_ref <= '0;
        end else if (capture) begin
            mon_ref <= mon_in;
        end
    end

    // Per-monitor change detection, gated or ungated by position.
    for (genvar i = 0; i < NMON; i++) begin : g_mon
        if (i < NGATED) begin : g_gated
            assign hit[i] = in_sleep && hs_on && (mon_in[i] != mon_ref[i]);
        end else begin : g_free
            assign hit[i] = in_sleep && (mon_in[i] != mon_ref[i]);
        end
    end

    assign wake_vec = {in_sleep && lin_wake, in_sleep && can_wake, hit};
    assign wake_any = |wake_vec;

    AST_NO_WAKE_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_sleep |-> !wake_any); // R8
endmodule

// File: rtl/ss_mode_fsm.sv
// Mode state machine: active, standby, sleep; holds the timing codes.
// Assumes: wake_any is only asserted in sleep; wake beats any command.
module ss_mode_fsm
    import ss_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_mode,
    input  logic [1:0] cmd_period,
    input  logic       cmd_ontime,
    input  logic       mon_init_ok,
    input  logic       wake_any,
    output md_e        md,
    output logic [1:0] per_code,
    output logic       on_code,
    output logic       capture,
    output logic       act_cmd
);
    md_e  md_nxt;
    logic in_sleep;

    assign in_sleep = (md == MD_SLEEP);

    // Next mode: wake first, then the host command.
    always_comb begin
        md_nxt = md;
        if (in_sleep && wake_any) begin
            md_nxt = MD_STANDBY;
        end else if (cmd_valid) begin
            if (!cmd_mode[2]) begin
                md_nxt = MD_ACTIVE;
            end else if (cmd_mode == CMD_SLEEP) begin
                if (!in_sleep) begin
                    md_nxt = mon_init_ok ? MD_SLEEP : MD_STANDBY;
                end
            end else begin
                md_nxt = MD_STANDBY;
            end
        end
    end

    // Strobes for reference capture and active-command acceptance.
    assign capture = cmd_valid && (cmd_mode == CMD_SLEEP) && !in_sleep && mon_init_ok;
    assign act_cmd = cmd_valid && !cmd_mode[2] && !(in_sleep && wake_any);

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            md <= MD_STANDBY;
        end else begin
            md <= md_nxt;
        end
    end

    // Timing codes, latched from commands accepted outside sleep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_code <= 2'd0;
            on_code  <= 1'b0;
        end else if (cmd_valid && !in_sleep) begin
            per_code <= cmd_period;
            on_code  <= cmd_ontime;
        end
    end

    AST_SLEEP_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (md == MD_SLEEP && $past(md) != MD_SLEEP)
        |-> $past(cmd_valid && cmd_mode == CMD_SLEEP && mon_init_ok)); // R2
    AST_INIT_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_mode == CMD_SLEEP && !mon_init_ok && md != MD_SLEEP)
        |=> (md == MD_STANDBY)); // R3
    AST_WAKE_STBY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sleep && wake_any) |=> (md == MD_STANDBY)); // R8
endmodule

// File: rtl/ss_wake_status.sv
// Wake-source status with read-clear, and per-transceiver pull-low flags.
// Assumes: wake_vec is already qualified; set wins over read-clear.
module ss_wake_status #(
    parameter int unsigned WV      = 6,
    parameter int unsigned CAN_IDX = 4,
    parameter int unsigned LIN_IDX = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [WV-1:0] wake_vec,
    input  logic          stat_rd,
    input  logic          act_cmd,
    output logic [WV-1:0] wake_src,
    output logic          can_flag,
    output logic          lin_flag
);
    // Accumulate accepted sources; a read clears older bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_src <= '0;
        end else begin
            wake_src <= (stat_rd ? '0 : wake_src) | wake_vec;
        end
    end

    // Pull-low flags: set on own wake, cleared by an active command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            can_flag <= 1'b0;
            lin_flag <= 1'b0;
        end else begin
            if (wake_vec[CAN_IDX])  can_flag <= 1'b1;
            else if (act_cmd)       can_flag <= 1'b0;
            if (wake_vec[LIN_IDX])  lin_flag <= 1'b1;
            else if (act_cmd)       lin_flag <= 1'b0;
        end
    end

    AST_CAN_FLAG_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(can_flag) |-> $past(wake_vec[CAN_IDX])); // R10
    AST_SRC_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> ((wake_src & $past(wake_src)) == $past(wake_src))); // R9
endmodule

// File: rtl/sense_sleep_ctrl.sv
// Top of the cyclic-sense sleep controller: mode FSM, sense timer,
// wake qualifier and wake status.
// Assumes: tick is a one-cycle enable at 10 kHz; inputs are synchronous.
module sense_sleep_ctrl
    import ss_pkg::*;
#(
    parameter int unsigned NMON     = 4,
    parameter int unsigned NGATED   = 3,
    parameter int unsigned CNT_W    = 12,
    parameter int unsigned PER_BASE = 160,
    parameter int unsigned ON_SHORT = 1,
    parameter int unsigned ON_LONG  = 10,
    localparam int unsigned WV      = NMON + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_mode,
    input  logic [1:0]      cmd_period,
    input  logic            cmd_ontime,
    input  logic            mon_init_ok,
    input  logic            stat_rd,
    input  logic [NMON-1:0] mon_in,
    input  logic            can_wake,
    input  logic            lin_wake,
    output logic            reg_en,
    output logic            can_en,
    output logic            lin_en,
    output logic            hs_en,
    output logic            can_rxd_low,
    output logic            lin_rxd_low,
    output logic [WV-1:0]   wake_src,
    output logic [1:0]      mode_o
);
    md_e           md;
    logic [1:0]    per_code;
    logic          on_code;
    logic          capture;
    logic          act_cmd;
    logic          wake_any;
    logic [WV-1:0] wake_vec;
    logic          in_sleep;

    assign in_sleep = (md == MD_SLEEP);

    ss_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_mode    (cmd_mode),
        .cmd_period  (cmd_period),
        .cmd_ontime  (cmd_ontime),
        .mon_init_ok (mon_init_ok),
        .wake_any    (wake_any),
        .md          (md),
        .per_code    (per_code),
        .on_code     (on_code),
        .capture     (capture),
        .act_cmd     (act_cmd)
    );

    ss_sense_timer #(
        .CNT_W    (CNT_W),
        .PER_BASE (PER_BASE),
        .ON_SHORT (ON_SHORT),
        .ON_LONG  (ON_LONG)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (in_sleep),
        .tick     (tick),
        .per_code (per_code),
        .on_code  (on_code),
        .hs_on    (hs_en)
    );

    ss_wake_detect #(
        .NMON   (NMON),
        .NGATED (NGATED)
    ) u_wdet (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .in_sleep (in_sleep),
        .hs_on    (hs_en),
        .mon_in   (mon_in),
        .can_wake (can_wake),
        .lin_wake (lin_wake),
        .wake_vec (wake_vec),
        .wake_any (wake_any)
    );

    ss_wake_status #(
        .WV      (WV),
        .CAN_IDX (NMON),
        .LIN_IDX (NMON + 1)
    ) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .wake_vec (wake_vec),
        .stat_rd  (stat_rd),
        .act_cmd  (act_cmd),
        .wake_src (wake_src),
        .can_flag (can_rxd_low),
        .lin_flag (lin_rxd_low)
    );

    // Supply enables decoded from the mode.
    assign reg_en = !in_sleep;
    assign can_en = (md == MD_ACTIVE);
    assign lin_en = (md == MD_ACTIVE);
    assign mode_o = md;

    AST_HS_REG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        hs_en |-> (!reg_en && !can_en && !lin_en)); // R5
    AST_GATED_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_src[0]) |-> $past(hs_en)); // R6
    AST_LIN_FLAG_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lin_rxd_low) |-> $past(lin_wake)); // R10
endmodule

// File: tb/sim_sense_sleep_ctrl.sv
module sim_sense_sleep_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_mode = 3'b0;
    logic [1:0] cmd_period = 2'b0;
    logic       cmd_ontime = 1'b0;
    logic       mon_init_ok = 1'b1;
    logic       stat_rd = 1'b0;
    logic [3:0] mon_in = 4'b0;
    logic       can_wake = 1'b0;
    logic       lin_wake = 1'b0;
    logic       reg_en, can_en, lin_en, hs_en, can_rxd_low, lin_rxd_low;
    logic [5:0] wake_src;
    logic [1:0] mode_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    sense_sleep_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid),
        .cmd_mode(cmd_mode), .cmd_period(cmd_period), .cmd_ontime(cmd_ontime),
        .mon_init_ok(mon_init_ok), .stat_rd(stat_rd), .mon_in(mon_in),
        .can_wake(can_wake), .lin_wake(lin_wake), .reg_en(reg_en),
        .can_en(can_en), .lin_en(lin_en), .hs_en(hs_en),
        .can_rxd_low(can_rxd_low), .lin_rxd_low(lin_rxd_low),
        .wake_src(wake_src), .mode_o(mode_o)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at cycle %0d", tag, got, exp, cyc);
        end
    endtask

    function automatic int per_ticks(input logic [1:0] code);
        return 160 << code;
    endfunction

    function automatic int on_ticks(input logic code);
        return code ? 10 : 1;
    endfunction

    // Cycle model built from the requirements.
    int         m_md = 0, m_cnt = 0;
    logic       m_ph = 0, m_on = 0, m_cf = 0, m_lf = 0;
    logic [1:0] m_per = 0;
    logic [3:0] m_ref = 0;
    logic [5:0] m_src = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_md = 0; m_ph = 0; m_cnt = 0; m_per = 0; m_on = 0;
            m_ref = 0; m_src = 0; m_cf = 0; m_lf = 0;
        end else begin
            logic       sl;
            logic       act;
            logic [5:0] v;
            int         lim;
            int         nmd;
            sl = (m_md == 2);
            v = 6'b0;
            for (int i = 0; i < 4; i++)
                if (sl && mon_in[i] != m_ref[i] && (i == 3 || m_ph)) v[i] = 1'b1;
            v[4] = sl && can_wake;
            v[5] = sl && lin_wake;
            act = cmd_valid && !cmd_mode[2] && (v == 6'b0);
            m_src = (stat_rd ? 6'b0 : m_src) | v;
            if (v[4]) m_cf = 1'b1; else if (act) m_cf = 1'b0;
            if (v[5]) m_lf = 1'b1; else if (act) m_lf = 1'b0;
            if (sl) begin
                if (tick) begin
                    lim = m_ph ? on_ticks(m_on) : per_ticks(m_per);
                    if (m_cnt == lim - 1) begin m_cnt = 0; m_ph = !m_ph; end
                    else m_cnt++;
                end
            end else begin
                m_cnt = 0; m_ph = 1'b0;
            end
            nmd = m_md;
            if (sl && v != 6'b0) nmd = 0;
            else if (cmd_valid) begin
                if (!cmd_mode[2]) nmd = 1;
                else if (cmd_mode == 3'b100) begin
                    if (!sl) begin
                        nmd = mon_init_ok ? 2 : 0;
                        if (mon_init_ok) m_ref = mon_in;
                    end
                end else nmd = 0;
            end
            if (cmd_valid && !sl) begin m_per = cmd_period; m_on = cmd_ontime; end
            m_md = nmd;
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 mode", mode_o, m_md);
            chk("R2 reg_en", reg_en, m_md != 2);
            chk("R4 xcvr_en", {can_en, lin_en}, (m_md == 1) ? 3 : 0);
            chk("R5 hs_en", hs_en, (m_md == 2) && m_ph);
            chk("R9 wake_src", wake_src, m_src);
            chk("R10 flags", {can_rxd_low, lin_rxd_low}, {m_cf, m_lf});
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got %0d expected <190000 cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic cmd(input logic [2:0] md, input logic [1:0] per,
                       input logic ont, input logic ok);
        cmd_valid = 1'b1; cmd_mode = md; cmd_period = per;
        cmd_ontime = ont; mon_init_ok = ok;
        @(negedge clk);
        cmd_valid = 1'b0; mon_init_ok = 1'b1;
    endtask

    initial begin
        int n;
        bit fast;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 mode", mode_o, 0);
        chk("R1 enables", {reg_en, can_en, lin_en, hs_en}, 4'b1000);
        chk("R1 status", {wake_src, can_rxd_low, lin_rxd_low}, 0);

        // R2/R5/R6: sleep, off-phase monitor glitch ignored, then gated wake
        tick = 1'b1;
        cmd(3'b100, 2'd0, 1'b1, 1'b1);
        chk("R2 sleep enables", {mode_o, reg_en, can_en, lin_en}, {2'd2, 3'b000});
        n = 0;
        while (!hs_en) begin
            n++;
            if (n == 50) mon_in[0] = 1'b1;
            if (n == 60) mon_in[0] = 1'b0;
            @(negedge clk);
        end
        chk("R5 off ticks code0", n, 160);
        chk("R6 off-phase change ignored", {mode_o, wake_src}, {2'd2, 6'b0});
        n = 0;
        while (hs_en) begin n++; @(negedge clk); end
        chk("R5 on ticks long", n, 10);
        while (!hs_en) @(negedge clk);
        mon_in[2] = 1'b1;
        @(negedge clk);
        chk("R6 on-phase wake", mode_o, 0);
        chk("R9 src mon3", wake_src, 6'b000100);
        chk("R8 regulator back", reg_en, 1);

        // R9: read clears
        stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
        chk("R9 read clear", wake_src, 0);

        // R7/R10: CAN wake in off phase, flag cleared by active command
        cmd(3'b100, 2'd1, 1'b0, 1'b1);
        repeat (20) @(negedge clk);
        can_wake = 1'b1; @(negedge clk); can_wake = 1'b0;
        chk("R7 can wake off phase", mode_o, 0);
        chk("R10 can flag set", {can_rxd_low, lin_rxd_low}, 2'b10);
        cmd(3'b110, 2'd0, 1'b0, 1'b1);
        chk("R10 flag held in standby cmd", can_rxd_low, 1);
        cmd(3'b010, 2'd0, 1'b0, 1'b1);
        chk("R10 flag cleared by active", can_rxd_low, 0);
        chk("R4 active enables", {reg_en, can_en, lin_en}, 3'b111);

        // R3: failed initialisation
        cmd(3'b100, 2'd0, 1'b0, 1'b0);
        chk("R3 init fail standby", {mode_o, reg_en, can_en}, {2'd0, 2'b10});

        // R11: no tick, no progress; then short on-time
        tick = 1'b0;
        cmd(3'b100, 2'd0, 1'b0, 1'b1);
        repeat (400) @(negedge clk);
        chk("R11 frozen without tick", {mode_o, hs_en}, {2'd2, 1'b0});
        tick = 1'b1;
        n = 0;
        while (!hs_en) begin n++; @(negedge clk); end
        chk("R11 off ticks after resume", n, 160);
        n = 0;
        while (hs_en) begin n++; @(negedge clk); end
        chk("R5 on ticks short", n, 1);

        // R8: wake beats active command in same cycle; R7 LIN wake
        lin_wake = 1'b1;
        cmd(3'b000, 2'd0, 1'b0, 1'b1);
        lin_wake = 1'b0;
        chk("R8 wake beats command", mode_o, 0);
        chk("R7 lin src", wake_src[5], 1);
        // R8: wake inputs outside sleep have no effect
        stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
        can_wake = 1'b1; mon_in[3] = ~mon_in[3]; @(negedge clk); can_wake = 1'b0;
        chk("R8 ignored outside sleep", {mode_o, wake_src, can_rxd_low}, 0);

        // Random phase
        fast = 1'b1;
        for (int c = 0; c < 60000; c++) begin
            int r;
            if (c % 5000 == 0) fast = ~fast;
            cmd_valid = 1'b0; can_wake = 1'b0; lin_wake = 1'b0;
            stat_rd = ($urandom % 40) == 0;
            if (mode_o != 2) begin
                if ($urandom % 30 == 0) begin
                    cmd_valid = 1'b1;
                    r = $urandom % 10;
                    if (r < 6) cmd_mode = 3'b100;
                    else if (r < 8) cmd_mode = {1'b0, 2'($urandom)};
                    else cmd_mode = 3'b101 + 3'($urandom % 3);
                    cmd_period = 2'($urandom);
                    cmd_ontime = 1'($urandom);
                    mon_init_ok = ($urandom % 10) != 0;
                end
            end else if ($urandom % 5000 == 0) begin
                cmd_valid = 1'b1; cmd_mode = 3'($urandom % 8);
            end
            for (int i = 0; i < 4; i++)
                if ($urandom % 2500 == 0) mon_in[i] = ~mon_in[i];
            if ($urandom % 6000 == 0) can_wake = 1'b1;
            if ($urandom % 6000 == 0) lin_wake = 1'b1;
            tick = fast ? 1'b1 : 1'($urandom);
            @(negedge clk);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule